// File: doc/BRIEF.md
# SPI Streaming Cipher-State Buffer

This block is an SPI slave that fronts a 16-byte state buffer shared with an external block cipher engine. A host opens a burst with a command byte and a start address, then streams bytes into consecutive addresses of a small register window. During a burst each incoming byte overwrites a buffer location. In the same burst, the value that location held before the write is shifted back to the host one byte later. This lets the host load the next plaintext while it reads back the previous result, all in one transaction.

The window holds a status byte, a control byte, the sixteen state bytes and a mirror of the control byte placed just after the last state byte. A burst that writes the mirror with its start bit set sends a one-cycle launch pulse to the engine, unless the engine reports busy. When the engine finishes, a done pulse loads its 16-byte result into the buffer. The host collects that result with a further burst, whose written data can be anything. The SPI pins are sampled by the system clock through synchronizers, so the system clock must run several times faster than the serial clock.

Top module: `fa_aes_spi_buf`

## Requirements
- R1: SPI mode 0, MSB first. While chip-select is high the MISO pin is held at 0. During the command byte the slave returns the status byte: bit 7 is the engine busy level and bits 6..0 are 0.
- R2: Byte 0 of a burst is the command, where 0x60 means write. Byte 1 is the start address. Every later byte goes to the current address, and the address then increments by one.
- R3: During byte 1 and the first data byte, MISO returns 0x00. During each later data byte it returns the value that the previous byte's address held just before that previous byte was written.
- R4: A write to addresses 0x84..0x93 stores the byte in state byte (address − 0x84). State byte i appears on eng_data[8i+7:8i].
- R5: Addresses 0x83 and 0x94 share one control register. A write stores the byte with bit 7 cleared, a read at either address returns it, and its bit 0 drives run_mode.
- R6: A write to 0x94 with bit 7 set gives exactly one run_start pulse of one cycle. A write to 0x83 with bit 7 set gives none.
- R7: A write to 0x94 with bit 7 set while eng_busy is high gives no run_start pulse.
- R8: Writes to 0x82, or to any address outside 0x82..0x94, change nothing. Reads outside the window return 0x00, and a read of 0x82 returns the status byte.
- R9: A burst whose command is not 0x60 writes nothing, but it still returns the window contents with the lag described in R3.
- R10: An eng_done pulse loads eng_result into the buffer, with byte i taken from eng_result[8i+7:8i]. A following burst returns these bytes with the lag described in R3.
- R11: Raising chip-select in the middle of a byte discards that byte. The next burst starts again with a command byte.
- R12: After reset the buffer and the control register are 0, and run_start, run_mode and MISO are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | One-cycle pulse when the engine result is valid |
| eng_result | input | 128 | Engine result, byte i in bits 8i+7:8i |
| eng_data | output | 128 | State buffer contents sent to the engine |
| run_start | output | 1 | One-cycle pulse that launches the engine |
| run_mode | output | 1 | Chaining mode select, taken from control bit 0 |

## Verification
On every cycle, the assertions check four things: MISO stays quiet while the slave is deselected, every launch pulse lasts one cycle and never follows a busy cycle, a done pulse copies the result into the buffer, and the buffer holds its value when there is neither a write nor a done pulse. Other behaviours can only be shown by the bench's scenarios, because each depends on a whole burst. These are the one-byte read lag and its read-before-overwrite order, the address decoding at the window edges, the shared control register, the effect of a non-write command, and recovery after a burst aborted mid-byte.

// File: rtl/fa_aes_pkg.sv
package fa_aes_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;

  typedef enum logic [2:0] {RG_NONE, RG_STATUS, RG_CTRL, RG_MIRROR, RG_STATE} reg_kind_t;

  // Classify one window address.
  function automatic reg_kind_t classify(input logic [7:0] a, input logic [7:0] stat_a,
                                         input logic [7:0] ctrl_a, input logic [7:0] base_a,
                                         input logic [7:0] mir_a);
    if (a == stat_a)                  return RG_STATUS;
    else if (a == ctrl_a)             return RG_CTRL;
    else if (a == mir_a)              return RG_MIRROR;
    else if (a >= base_a && a < mir_a) return RG_STATE;
    else                              return RG_NONE;
  endfunction

  // Status byte: busy in the top bit.
  function automatic logic [7:0] status_of(input logic busy);
    return {busy, 7'd0};
  endfunction

  // Stored control value: the launch bit never persists.
  function automatic logic [7:0] strip_bit(input logic [7:0] v, input int bitpos);
    return v & ~(8'd1 << bitpos);
  endfunction

endpackage

// File: rtl/fa_spi_link.sv
module fa_spi_link #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       sel,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  input  logic [7:0] status_in,
  input  logic [7:0] tx_next
);
  logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s, mosi_s;
  logic rise, fall, open_evt;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sel      = ~cs_s;
  assign rise     = sel & sclk_s & ~sclk_d;
  assign fall     = sel & ~sclk_s & sclk_d;
  assign open_evt = ~cs_s & cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_sh     <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh, mosi_s};
        end
      end
      if (open_evt)                      tx_sh <= status_in;
      else if (byte_done)                tx_sh <= tx_next;
      else if (fall && bit_cnt != 3'd0)  tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign miso = sel & tx_sh[7];
endmodule

// File: rtl/fa_frame_ctrl.sv
module fa_frame_ctrl
  import fa_aes_pkg::*;
#(
  parameter logic [7:0] CMD_WR = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  output logic [7:0] tx_next
);
  phase_t     phase;
  logic       is_write;
  logic [7:0] addr;

  assign rd_addr = addr;
  assign wr_addr = addr;
  assign wr_data = rx_byte;
  assign tx_next = (phase == PH_DATA) ? rd_data : 8'h00;
  assign wr_en   = sel && byte_done && phase == PH_DATA && is_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      is_write <= 1'b0;
      addr     <= '0;
    end else if (!sel) begin
      phase    <= PH_CMD;
      is_write <= 1'b0;
    end else if (byte_done) begin
      unique case (phase)
        PH_CMD: begin
          is_write <= (rx_byte == CMD_WR);
          phase    <= PH_ADDR;
        end
        PH_ADDR: begin
          addr  <= rx_byte;
          phase <= PH_DATA;
        end
        default: addr <= addr + 8'd1;
      endcase
    end
  end
endmodule

// File: rtl/fa_state_regs.sv
module fa_state_regs
  import fa_aes_pkg::*;
#(
  parameter int         NBYTES      = 16,
  parameter logic [7:0] STATUS_ADDR = 8'h82,
  parameter logic [7:0] CTRL_ADDR   = 8'h83,
  parameter logic [7:0] BASE_ADDR   = 8'h84,
  parameter int         START_BIT   = 7,
  localparam int        DATA_W      = 8 * NBYTES,
  localparam logic [7:0] MIRROR_ADDR = BASE_ADDR + 8'(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_result,
  output logic [7:0]        rd_data,
  output logic [7:0]        status_byte,
  output logic [DATA_W-1:0] state_flat,
  output logic [7:0]        ctrl_q,
  output logic              run_start
);
  logic [7:0] buf_q [NBYTES];
  reg_kind_t  wr_kind, rd_kind;

  assign status_byte = status_of(eng_busy);
  assign wr_kind = classify(wr_addr, STATUS_ADDR, CTRL_ADDR, BASE_ADDR, MIRROR_ADDR);
  assign rd_kind = classify(rd_addr, STATUS_ADDR, CTRL_ADDR, BASE_ADDR, MIRROR_ADDR);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_addr == BASE_ADDR + 8'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)        buf_q[i] <= '0;
      else if (hit)      buf_q[i] <= wr_data;
      else if (eng_done) buf_q[i] <= eng_result[8*i +: 8];
    end
    assign state_flat[8*i +: 8] = buf_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      run_start <= 1'b0;
    end else begin
      if (wr_en && (wr_kind == RG_CTRL || wr_kind == RG_MIRROR))
        ctrl_q <= strip_bit(wr_data, START_BIT);
      run_start <= wr_en && wr_kind == RG_MIRROR && wr_data[START_BIT] && !eng_busy;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    unique case (rd_kind)
      RG_STATUS:           rd_data = status_byte;
      RG_CTRL, RG_MIRROR:  rd_data = ctrl_q;
      RG_STATE: begin
        for (int i = 0; i < NBYTES; i++)
          if (rd_addr == BASE_ADDR + 8'(i)) rd_data = buf_q[i];
      end
      default:             rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/fa_aes_spi_buf.sv
module fa_aes_spi_buf #(
  parameter int         NBYTES      = 16,
  parameter logic [7:0] CMD_WR      = 8'h60,
  parameter logic [7:0] STATUS_ADDR = 8'h82,
  parameter logic [7:0] CTRL_ADDR   = 8'h83,
  parameter logic [7:0] BASE_ADDR   = 8'h84,
  parameter int         START_BIT   = 7,
  parameter int         MODE_BIT    = 0,
  parameter int         SYNC_STAGES = 2,
  localparam int        DATA_W      = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_result,
  output logic [DATA_W-1:0] eng_data,
  output logic              run_start,
  output logic              run_mode
);
  logic       sel, byte_done, wr_en;
  logic [7:0] rx_byte, status_byte, tx_next, rd_data, rd_addr, wr_addr, wr_data, ctrl_q;

  fa_spi_link #(.SYNC_STAGES(SYNC_STAGES)) link_i (
    .clk, .rst_n, .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
    .sel, .byte_done, .rx_byte, .status_in(status_byte), .tx_next
  );

  fa_frame_ctrl #(.CMD_WR(CMD_WR)) frame_i (
    .clk, .rst_n, .sel, .byte_done, .rx_byte, .rd_data,
    .wr_en, .wr_addr, .wr_data, .rd_addr, .tx_next
  );

  fa_state_regs #(
    .NBYTES(NBYTES), .STATUS_ADDR(STATUS_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .BASE_ADDR(BASE_ADDR), .START_BIT(START_BIT)
  ) regs_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .eng_busy, .eng_done,
    .eng_result, .rd_data, .status_byte, .state_flat(eng_data), .ctrl_q, .run_start
  );

  assign run_mode = ctrl_q[MODE_BIT];
endmodule

// File: rtl/fa_aes_spi_buf_chk.sv
module fa_aes_spi_buf_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              eng_busy,
  input logic              eng_done,
  input logic [DATA_W-1:0] eng_result,
  input logic [DATA_W-1:0] eng_data,
  input logic              run_start,
  input logic              wr_en
);
  // R1
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> !$past(eng_busy));

  // R10
  done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eng_done) && !$past(wr_en)) |-> (eng_data == $past(eng_result)));

  // R8
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(eng_done)) |-> $stable(eng_data));
endmodule

bind fa_aes_spi_buf fa_aes_spi_buf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk, .rst_n, .spi_cs_n, .spi_miso, .eng_busy, .eng_done,
  .eng_result, .eng_data, .run_start, .wr_en(wr_en)
);

// File: tb/fa_aes_spi_buf_tb_top.sv
module fa_aes_spi_buf_tb_top;
  localparam int NB = 16;
  localparam int DW = 8 * NB;
  // cmd, start addr, cfg, seed, data byte count
  localparam logic [39:0] VECS [0:6] = '{
    40'h60_83_81_10_12, 40'h60_83_80_40_12, 40'h20_83_81_77_12,
    40'h60_88_00_05_06, 40'h60_90_80_33_08, 40'h60_82_00_99_03,
    40'h60_7F_01_21_06
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic eng_busy = 1'b0, eng_done = 1'b0;
  logic [DW-1:0] eng_result = '0;
  wire miso, run_start, run_mode;
  wire [DW-1:0] eng_data;

  fa_aes_spi_buf dut_i (
    .clk, .rst_n, .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .eng_busy, .eng_done, .eng_result, .eng_data, .run_start, .run_mode
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0, start_cnt = 0, exp_starts = 0;
  logic [7:0] tx_q [0:31];
  logic [7:0] rx_q [0:31];
  logic [7:0] exp_q [0:31];
  logic [7:0] mbuf [0:NB-1];
  logic [7:0] mctrl = 8'h00;
  logic busy_m = 1'b0;

  always @(posedge clk) if (rst_n && run_start) start_cnt++;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a == 8'h82) return busy_m ? 8'h80 : 8'h00;
    if (a == 8'h83 || a == 8'h94) return mctrl;
    if (a >= 8'h84 && a <= 8'h93) return mbuf[a - 8'h84];
    return 8'h00;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] v);
    if (a == 8'h83 || a == 8'h94) mctrl = {1'b0, v[6:0]};
    if (a == 8'h94 && v[7] && !busy_m) exp_starts++;
    if (a >= 8'h84 && a <= 8'h93) mbuf[a - 8'h84] = v;
  endtask

  function automatic logic [DW-1:0] mflat();
    logic [DW-1:0] f;
    for (int i = 0; i < NB; i++) f[8*i +: 8] = mbuf[i];
    return f;
  endfunction

  task automatic fill(input logic [7:0] cmd, input logic [7:0] ad, input logic [7:0] cfg,
                      input logic [7:0] seed, input int n);
    tx_q[0] = cmd;
    tx_q[1] = ad;
    for (int j = 0; j < n; j++) begin
      logic [7:0] a;
      a = ad + 8'(j);
      tx_q[j+2] = (a == 8'h83 || a == 8'h94) ? cfg : (seed ^ 8'(j * 29));
    end
  endtask

  task automatic predict(input int n);
    logic [7:0] pend;
    exp_starts = 0;
    pend = 8'h00;
    exp_q[0] = busy_m ? 8'h80 : 8'h00;
    exp_q[1] = 8'h00;
    for (int j = 0; j < n; j++) begin
      logic [7:0] a;
      a = tx_q[1] + 8'(j);
      exp_q[j+2] = (j == 0) ? 8'h00 : pend;
      pend = mread(a);
      if (tx_q[0] == 8'h60) mwrite(a, tx_q[j+2]);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = b[i];
      repeat (6) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input int tot);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < tot; k++) spi_byte(tx_q[k], 8, rx_q[k]);
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_burst(input int n, input string req);
    int s0, bad;
    predict(n);
    s0 = start_cnt;
    xfer(n + 2);
    bad = -1;
    for (int k = n + 1; k >= 0; k--) if (rx_q[k] !== exp_q[k]) bad = k;
    if (bad < 0) check(1'b1, req, '0, '0);
    else check(1'b0, req, DW'(rx_q[bad]), DW'(exp_q[bad]));
    check(eng_data === mflat(), "R4 buffer contents", eng_data, mflat());
    check(start_cnt - s0 == exp_starts, "R6 launch count", DW'(start_cnt - s0), DW'(exp_starts));
    check(run_mode === mctrl[0], "R5 mode bit", DW'(run_mode), DW'(mctrl[0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < NB; i++) mbuf[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check(miso === 1'b0, "R12 miso after reset", DW'(miso), '0);
    check(eng_data === '0, "R12 buffer after reset", eng_data, '0);
    check(run_start === 1'b0 && run_mode === 1'b0, "R12 start/mode after reset",
          DW'({run_start, run_mode}), '0);

    // Table walk: R2 R3 R8 R9 streams
    for (int v = 0; v < 7; v++) begin
      fill(VECS[v][39:32], VECS[v][31:24], VECS[v][23:16], VECS[v][15:8], int'(VECS[v][7:0]));
      do_burst(int'(VECS[v][7:0]), $sformatf("R3 lagged stream vector %0d", v));
    end

    // R10 engine result load, then a dummy burst returns it
    for (int i = 0; i < NB; i++) eng_result[8*i +: 8] = 8'hA5 ^ 8'(i * 17);
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    for (int i = 0; i < NB; i++) mbuf[i] = eng_result[8*i +: 8];
    @(negedge clk);
    check(eng_data === eng_result, "R10 result loaded", eng_data, eng_result);
    fill(8'h60, 8'h83, 8'h00, 8'h5C, 18);
    do_burst(18, "R10 result read back");

    // R7 launch refused while busy, status shows busy (R1)
    eng_busy = 1'b1;
    busy_m = 1'b1;
    fill(8'h60, 8'h83, 8'h81, 8'h3E, 18);
    do_burst(18, "R7 busy frame");
    eng_busy = 1'b0;
    busy_m = 1'b0;

    // R6 start bit written at the control address only
    fill(8'h60, 8'h83, 8'h81, 8'h00, 1);
    do_burst(1, "R6 start bit at control address");

    // R11 burst aborted mid-byte
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    spi_byte(8'h60, 8, junk);
    spi_byte(8'h84, 8, junk);
    spi_byte(8'hFF, 4, junk);
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    fill(8'h20, 8'h84, 8'h00, 8'h11, 17);
    do_burst(17, "R11 recovery after abort");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule